// File: doc/BRIEF.md
# DDR3 Command and Bank-State Tracker

This block sits beside a DDR3 command/address bus and reads it on every rising clock edge. It turns each cycle into one decoded command strobe with its bank, row or column field, auto-precharge flag and effective burst length. It keeps an open-row bit for each of the eight banks, and it keeps the burst setting that mode register 0 last loaded. It also follows the clock-enable pin into and out of the low-power states. Any later stage that needs a clean, already-interpreted view of the command stream can use it, for example a protocol monitor, a statistics counter or a bus analyser.

All outputs are registered. The fields for the command sampled at edge N appear just after edge N, together with the bank and power state that this command leaves behind. The device organisation is set by a parameter (4, 8 or 16 data bits), and this parameter selects how the row and column fields are cut from the address.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: A cycle with `cs_n` high decodes no command: `cmd_valid` stays 0 and the bank state does not change.
- R2: With `cs_n` low, `cke` high and the tracker awake, `cmd_valid` is 1 after that edge. `cmd_code` equals {`ras_n`,`cas_n`,`we_n`} (0 mode load, 1 refresh, 2 precharge, 3 activate, 4 write, 5 read, 6 calibration, 7 no-op) and `cmd_bank` equals `ba`.
- R3: Activate (code 3) marks bank `ba` open. `cmd_row` is `addr[14:0]` for 4- and 8-bit devices and `addr[13:0]` for 16-bit devices.
- R4: Precharge (code 2) with `addr[10]`=0 closes only bank `ba`. With `addr[10]`=1 it closes every bank.
- R5: On read (5) or write (4), `auto_pre` equals `addr[10]`. `cmd_col` is {`addr[11]`,`addr[9:0]`} for 4-bit devices and `addr[9:0]` otherwise. With `addr[10]`=1 the open bank is closed after the access.
- R6: Mode load (code 0) with `ba`=0 stores `addr[1:0]` as the burst setting: 00 fixed 8, 01 chosen per access, 10 fixed 4. A mode load to any other `ba` leaves the setting unchanged. Reset sets 00.
- R7: On read or write, `burst_is8` is 0 under setting 10 and equals `addr[12]` under setting 01 (1 = 8, 0 = chopped 4). It is 1 under 00 and 11, and 1 on every cycle that is not a read or write.
- R8: `proto_err` pulses with `cmd_valid` for an activate to an open bank (the bank stays open) and for a read or write to a closed bank (the bank stays closed).
- R9: While awake, an edge with `cke` low decodes no command and enters a low-power state. It enters self-refresh (`pwr_state`=3) if `cs_n` is low with code 1. Otherwise it enters active power-down (2) if any bank is open, or precharge power-down (1) if none is.
- R10: In a low-power state no command is decoded and the bank state holds. The first edge with `cke` high returns `pwr_state` to 0, whatever `cs_n` and the command pins carry, and decodes no command on that edge.
- R11: During reset, `cmd_valid`, `proto_err`, `auto_pre`, `bank_open` and `pwr_state` are 0 and `burst_is8` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit |
| cas_n | input | 1 | Column strobe command bit |
| we_n | input | 1 | Write-enable command bit |
| ba | input | 3 | Bank select |
| addr | input | 15 | Address bus |
| cmd_valid | output | 1 | A command was decoded at the last edge |
| cmd_code | output | 3 | Decoded command code |
| cmd_bank | output | 3 | Bank of the decoded command |
| cmd_row | output | 15 | Row field (width follows device organisation) |
| cmd_col | output | 10 | Column field (width follows device organisation) |
| auto_pre | output | 1 | Read/write carries auto-precharge |
| burst_is8 | output | 1 | Effective burst is 8 (0 = chopped 4) |
| bank_open | output | 8 | Open-row bit per bank |
| pwr_state | output | 2 | 0 awake, 1 precharge power-down, 2 active power-down, 3 self-refresh |
| proto_err | output | 1 | Activate to open bank or access to closed bank |

## Verification
The assertions assume that every input is driven to a known level from time zero and changes only away from the rising edge. They also assume that a self-refresh entry edge always carries the refresh code. The bench drives all pins in full from time zero, changes them two nanoseconds after each edge, and holds `cs_n` high during reset. Because the asynchronous self-refresh exit is modelled as the first edge that samples `cke` high, the stimulus makes each `cke` change last at least one full cycle.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'd0,
    CMD_REF = 3'd1,
    CMD_PRE = 3'd2,
    CMD_ACT = 3'd3,
    CMD_WR  = 3'd4,
    CMD_RD  = 3'd5,
    CMD_ZQ  = 3'd6,
    CMD_NOP = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_AWAKE    = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;

  localparam logic [1:0] BLM_FIX8 = 2'b00;
  localparam logic [1:0] BLM_OTF  = 2'b01;
  localparam logic [1:0] BLM_FIX4 = 2'b10;

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  // Effective burst of a column access: 1 = eight beats, 0 = chopped four.
  function automatic logic burst8_of(input logic [1:0] mode, input logic a12);
    case (mode)
      BLM_OTF:  return a12;
      BLM_FIX4: return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

  // Column field: the 4-bit organisation skips bit 10 (auto-precharge).
  function automatic logic [10:0] col_of(input logic [15:0] a, input int dev_w);
    if (dev_w == 4) return {a[11], a[9:0]};
    return {1'b0, a[9:0]};
  endfunction

endpackage

// File: rtl/trk_cmd_decode.sv
module trk_cmd_decode
  import ddr_trk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic awake,
  output logic issue,
  output cmd_e code
);
  assign code  = cmd_e'({ras_n, cas_n, we_n});
  assign issue = awake & cke & ~cs_n;
endmodule

// File: rtl/trk_bank_table.sv
module trk_bank_table
  import ddr_trk_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue,
  input  cmd_e                 code,
  input  logic [BANK_W-1:0]    bank,
  input  logic                 a10,
  output logic [NUM_BANKS-1:0] open_vec,
  output logic                 err_evt
);
  logic act_evt, pre_evt, pre_one_evt, pre_all_evt, acc_evt, acc_close_evt;

  assign act_evt       = issue && (code == CMD_ACT);
  assign pre_evt       = issue && (code == CMD_PRE);
  assign pre_one_evt   = pre_evt && !a10;
  assign pre_all_evt   = pre_evt && a10;
  assign acc_evt       = issue && is_access(code);
  assign acc_close_evt = acc_evt && a10;
  assign err_evt       = (act_evt && open_vec[bank]) || (acc_evt && !open_vec[bank]);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit, set_i, clr_i, bit_q;
    assign hit   = (bank == BANK_W'(i));
    assign set_i = act_evt && hit;
    assign clr_i = pre_all_evt || ((pre_one_evt || acc_close_evt) && hit);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bit_q <= 1'b0;
      else if (set_i) bit_q <= 1'b1;
      else if (clr_i) bit_q <= 1'b0;
    end
    assign open_vec[i] = bit_q;
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    act_evt |=> open_vec[$past(bank)]); // R3
  AST_PREALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_evt |=> (open_vec == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(open_vec)); // R1
  AST_AP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_close_evt |=> !open_vec[$past(bank)]); // R5
endmodule

// File: rtl/trk_power_fsm.sv
module trk_power_fsm
  import ddr_trk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic cs_n,
  input  cmd_e code,
  input  logic any_open,
  output pwr_e state
);
  pwr_e nxt;
  logic sr_entry;

  assign sr_entry = !cs_n && (code == CMD_REF);

  always_comb begin
    nxt = state;
    if (state == PWR_AWAKE) begin
      if (!cke) begin
        if (sr_entry)      nxt = PWR_SELF_REF;
        else if (any_open) nxt = PWR_ACT_PD;
        else               nxt = PWR_PRE_PD;
      end
    end else if (cke) begin
      nxt = PWR_AWAKE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PWR_AWAKE;
    else        state <= nxt;
  end

  AST_EXIT_ON_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PWR_AWAKE && cke) |=> (state == PWR_AWAKE)); // R10
  AST_LOWPWR_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state != PWR_AWAKE && !cke) |=> $stable(state)); // R10
  AST_ACTPD_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_AWAKE && !cke && !sr_entry && any_open) |=> (state == PWR_ACT_PD)); // R9
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_trk_pkg::*;
#(
  parameter int DEV_WIDTH = 8,
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 15,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int ROW_W  = (DEV_WIDTH == 16) ? ADDR_W - 1 : ADDR_W,
  localparam int COL_W  = (DEV_WIDTH == 4) ? 11 : 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cmd_valid,
  output logic [2:0]           cmd_code,
  output logic [BANK_W-1:0]    cmd_bank,
  output logic [ROW_W-1:0]     cmd_row,
  output logic [COL_W-1:0]     cmd_col,
  output logic                 auto_pre,
  output logic                 burst_is8,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic [1:0]           pwr_state,
  output logic                 proto_err
);
  localparam int PAD_W = 16 - ADDR_W;

  logic        issue, awake, err_evt, acc_evt, mode_load;
  cmd_e        code;
  pwr_e        pwr_q;
  logic [1:0]  bl_mode_q;
  logic [15:0] addr_ext;
  logic [10:0] col_full;

  assign awake     = (pwr_q == PWR_AWAKE);
  assign addr_ext  = {{PAD_W{1'b0}}, addr};
  assign col_full  = col_of(addr_ext, DEV_WIDTH);
  assign acc_evt   = issue && is_access(code);
  assign mode_load = issue && (code == CMD_MRS) && (ba == '0);

  trk_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .awake(awake), .issue(issue), .code(code)
  );

  trk_bank_table #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk(clk), .rst_n(rst_n), .issue(issue), .code(code), .bank(ba),
    .a10(addr[10]), .open_vec(bank_open), .err_evt(err_evt)
  );

  trk_power_fsm u_pwr (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .code(code),
    .any_open(|bank_open), .state(pwr_q)
  );

  assign pwr_state = pwr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bl_mode_q <= BLM_FIX8;
    else if (mode_load) bl_mode_q <= addr[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_NOP;
      cmd_bank  <= '0;
      cmd_row   <= '0;
      cmd_col   <= '0;
      auto_pre  <= 1'b0;
      burst_is8 <= 1'b1;
      proto_err <= 1'b0;
    end else begin
      cmd_valid <= issue;
      cmd_code  <= code;
      cmd_bank  <= ba;
      cmd_row   <= addr[ROW_W-1:0];
      cmd_col   <= col_full[COL_W-1:0];
      auto_pre  <= acc_evt && addr[10];
      burst_is8 <= acc_evt ? burst8_of(bl_mode_q, addr[12]) : 1'b1;
      proto_err <= err_evt;
    end
  end

  AST_CS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !cmd_valid); // R1
  AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q != PWR_AWAKE) |-> !cmd_valid); // R10
  AST_ERR_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> cmd_valid); // R8
  AST_FIXED_CHOP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && bl_mode_q == BLM_FIX4) |=> !burst_is8); // R7
  AST_BANKS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q != PWR_AWAKE) |=> $stable(bank_open)); // R10
endmodule

// File: tb/ddr_cmd_tracker_tb_top.sv
`timescale 1ns/1ps
module ddr_cmd_tracker_tb_top;
  localparam real HALF = 10.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [2:0]  ba = '0;
  logic [14:0] addr = '0;

  logic        cmd_valid, auto_pre, burst_is8, proto_err;
  logic [2:0]  cmd_code, cmd_bank;
  logic [14:0] cmd_row;
  logic [9:0]  cmd_col;
  logic [7:0]  bank_open;
  logic [1:0]  pwr_state;

  logic        v4, ap4, b4, e4, v16, ap16, b16, e16;
  logic [2:0]  c4, k4, c16, k16;
  logic [14:0] row4;
  logic [13:0] row16;
  logic [10:0] col4;
  logic [9:0]  col16;
  logic [7:0]  o4, o16;
  logic [1:0]  p4, p16;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_open = '0;
  logic [1:0] m_mode = 2'b00;
  logic [1:0] m_pwr  = 2'd0;

  always #(HALF) clk = ~clk;

  ddr_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col), .auto_pre(auto_pre),
    .burst_is8(burst_is8), .bank_open(bank_open), .pwr_state(pwr_state), .proto_err(proto_err)
  );

  ddr_cmd_tracker #(.DEV_WIDTH(4)) dut_x4_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_valid(v4), .cmd_code(c4),
    .cmd_bank(k4), .cmd_row(row4), .cmd_col(col4), .auto_pre(ap4),
    .burst_is8(b4), .bank_open(o4), .pwr_state(p4), .proto_err(e4)
  );

  ddr_cmd_tracker #(.DEV_WIDTH(16)) dut_x16_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_valid(v16), .cmd_code(c16),
    .cmd_bank(k16), .cmd_row(row16), .cmd_col(col16), .auto_pre(ap16),
    .burst_is8(b16), .bank_open(o16), .pwr_state(p16), .proto_err(e16)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one bus cycle, advance the model, check after the edge.
  task automatic cyc(input logic k, input logic c, input logic [2:0] op,
                     input logic [2:0] b, input logic [14:0] a, input string tag);
    logic issue, eerr, eap, eb8;
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = op; ba = b; addr = a;
    issue = (m_pwr == 2'd0) && k && !c;
    eerr = 1'b0; eap = 1'b0; eb8 = 1'b1;
    if (m_pwr == 2'd0 && !k)      m_pwr = (!c && op == 3'd1) ? 2'd3 : ((|m_open) ? 2'd2 : 2'd1);
    else if (m_pwr != 2'd0 && k)  m_pwr = 2'd0;
    else if (issue) begin
      case (op)
        3'd0: if (b == 3'd0) m_mode = a[1:0];
        3'd2: if (a[10]) m_open = '0; else m_open[b] = 1'b0;
        3'd3: if (m_open[b]) eerr = 1'b1; else m_open[b] = 1'b1;
        3'd4, 3'd5: begin
          eap = a[10];
          eb8 = (m_mode == 2'b01) ? a[12] : (m_mode != 2'b10);
          if (!m_open[b]) eerr = 1'b1;
          else if (a[10]) m_open[b] = 1'b0;
        end
        default: ;
      endcase
    end
    @(posedge clk); #2;
    chk(tag, "cmd_valid", cmd_valid, issue);
    chk(tag, "bank_open", bank_open, m_open);
    chk(tag, "pwr_state", pwr_state, m_pwr);
    chk(eerr ? "R8" : tag, "proto_err", proto_err, eerr);
    chk("R5", "auto_pre", auto_pre, eap);
    chk("R7", "burst_is8", burst_is8, eb8);
    if (issue) begin
      chk("R2", "cmd_code", cmd_code, op);
      chk("R2", "cmd_bank", cmd_bank, b);
      if (op == 3'd3) begin
        chk("R3", "row x8", cmd_row, a);
        chk("R3", "row x16", row16, a[13:0]);
      end
      if (op == 3'd4 || op == 3'd5) begin
        chk("R5", "col x8", cmd_col, a[9:0]);
        chk("R5", "col x4", col4, {a[11], a[9:0]});
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    chk("R11", "cmd_valid", cmd_valid, 0);
    chk("R11", "bank_open", bank_open, 0);
    chk("R11", "pwr_state", pwr_state, 0);
    chk("R11", "proto_err", proto_err, 0);
    chk("R11", "auto_pre", auto_pre, 0);
    chk("R11", "burst_is8", burst_is8, 1);
    rst_n = 1'b1;

    // R1: deselected activates change nothing
    for (int b = 0; b < 8; b++) cyc(1, 1, 3'd3, 3'(b), 15'h1234, "R1");
    // R3: open every bank, R8: second activate flags
    for (int b = 0; b < 8; b++) begin
      cyc(1, 0, 3'd3, 3'(b), 15'((b * 4099 + 16'h4005) & 16'h7fff), "R3");
      cyc(1, 0, 3'd3, 3'(b), 15'h0001, "R8");
    end
    cyc(1, 0, 3'd6, 3'd0, 15'h0400, "R2");
    cyc(1, 0, 3'd1, 3'd0, 15'h0000, "R2");
    cyc(1, 0, 3'd7, 3'd5, 15'h7fff, "R2");
    // R6/R7: burst setting sweep
    for (int md = 0; md < 4; md++) begin
      cyc(1, 0, 3'd0, 3'd0, 15'(md), "R6");
      for (int a12 = 0; a12 < 2; a12++) begin
        cyc(1, 0, 3'd5, 3'(md), 15'((a12 << 12) | (md * 173 + 2048 * a12)) & 15'h7bff, "R7");
        cyc(1, 0, 3'd4, 3'(md + 4), 15'((a12 << 12) | 15'h0a55) & 15'h7bff, "R7");
      end
    end
    cyc(1, 0, 3'd0, 3'd0, 15'h0002, "R6");
    cyc(1, 0, 3'd0, 3'd2, 15'h0000, "R6");
    cyc(1, 0, 3'd5, 3'd1, 15'h1000, "R6");
    // R5: auto-precharge closes, then R8 access to closed bank
    cyc(1, 0, 3'd5, 3'd3, 15'h0c7e, "R5");
    cyc(1, 0, 3'd4, 3'd3, 15'h0400, "R8");
    cyc(1, 0, 3'd5, 3'd3, 15'h0001, "R8");
    // R4: single and all-bank precharge
    cyc(1, 0, 3'd2, 3'd1, 15'h0000, "R4");
    cyc(1, 0, 3'd2, 3'd6, 15'h7bff, "R4");
    cyc(1, 0, 3'd2, 3'd0, 15'h0400, "R4");
    // R9/R10: precharge power-down, ignored command, exit
    cyc(0, 0, 3'd7, 3'd0, 15'h0000, "R9");
    cyc(0, 0, 3'd3, 3'd2, 15'h0000, "R10");
    cyc(1, 0, 3'd3, 3'd2, 15'h0000, "R10");
    // active power-down
    cyc(1, 0, 3'd3, 3'd2, 15'h0123, "R9");
    cyc(0, 1, 3'd7, 3'd0, 15'h0000, "R9");
    cyc(0, 0, 3'd2, 3'd2, 15'h0400, "R10");
    cyc(1, 1, 3'd7, 3'd0, 15'h0000, "R10");
    // self-refresh entry, hold, exit independent of command pins
    cyc(0, 0, 3'd1, 3'd0, 15'h0000, "R9");
    cyc(0, 1, 3'd3, 3'd4, 15'h7fff, "R10");
    cyc(0, 0, 3'd2, 3'd4, 15'h0400, "R10");
    cyc(1, 0, 3'd2, 3'd0, 15'h0400, "R10");
    cyc(1, 0, 3'd2, 3'd0, 15'h0400, "R4");
    // Near-exhaustive sweep over select, code and bank
    for (int c = 0; c < 2; c++)
      for (int op = 0; op < 8; op++)
        for (int b = 0; b < 8; b++)
          cyc(1, 1'(c), 3'(op), 3'(b), 15'((op * 811 + b * 97 + c * 5) & 16'h7fff), c ? "R1" : "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule